// File: doc/BRIEF.md
# Conic region raster generator

This block walks a raster in scan order and, at each pixel, produces the value of the quadratic f(x, y) = a·x² + b·y² + c·x + d·y + e. It uses no multiplier. Each output is built from the previous one by forward differences, so a handful of adders keep pace at one pixel per clock. The sign of f marks the pixel as inside or outside the shape. The value itself is also passed out, so a downstream stage can use it as a colour ramp.

Pixel timing arrives as three strobes. `pix_valid` marks a pixel cycle. `line_start` marks the first pixel of a line. `frame_start` marks the first pixel of a frame. A single set of five coefficients and a narrow-mode bit are captured at frame start, and the whole frame is drawn with them. In narrow mode the result is reduced to 8-bit two's complement, so overflow wraps around and gives folded, kaleidoscope-like patterns. In wide mode the accumulators are sized so that the full raster can never overflow.

Top module: `conic_raster`

## Requirements
- R1: In wide mode (`narrow` = 0 at frame start), each output `out_value` equals f(x, y) exactly, computed with the coefficients as signed integers. Here x is the number of valid pixels since the last line start and y is the number of line starts since the frame start (both 0 at the frame's first pixel).
- R2: `out_inside` is 1 exactly when the reported `out_value` is negative in two's complement.
- R3: `out_valid` is asserted exactly two clock cycles after a cycle with `pix_valid` = 1, and at no other time. Idle cycles between pixels do not advance x or y.
- R4: In narrow mode (`narrow` = 1 at frame start), `out_value` is the low 8 bits of f(x, y) sign-extended to the full width, so values wrap modulo 256 into the range −128..127.
- R5: Coefficients and the mode bit are taken only in a cycle with `frame_start` = 1 and `pix_valid` = 1. Changing them during a frame has no effect on that frame's outputs.
- R6: A cycle with `frame_start` = 1 is also a line start, and its pixel has x = 0 and y = 0, whatever `line_start` is.
- R7: `frame_start` and `line_start` are ignored in cycles where `pix_valid` = 0.
- R8: In wide mode with X_W = Y_W = 11 and COEF_W = 16, every coefficient at −32768 over rasters 2048 wide or 2048 tall still gives exact values (no overflow).
- R9: While reset is held and right after it, `out_valid`, `out_inside` and `out_value` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Current cycle carries a pixel |
| frame_start | input | 1 | First pixel of a frame; captures coefficients |
| line_start | input | 1 | First pixel of a line |
| narrow | input | 1 | Mode bit: 1 selects 8-bit wrapping result |
| coef_a | input | COEF_W | Signed coefficient of x² |
| coef_b | input | COEF_W | Signed coefficient of y² |
| coef_c | input | COEF_W | Signed coefficient of x |
| coef_d | input | COEF_W | Signed coefficient of y |
| coef_e | input | COEF_W | Signed constant term |
| out_valid | output | 1 | Result strobe, two cycles after pix_valid |
| out_value | output | ACC_W | Signed polynomial value |
| out_inside | output | 1 | Sign of out_value |

## Verification
The hardest state to reach is a set of accumulators near their limits. The row difference must have been stepped about two thousand times, or the pixel difference carried across a whole line, with every coefficient at its most negative value. The stimulus gets there with one raster 2048 pixels wide and another 2048 lines tall, and compares each output with a direct evaluation of the polynomial. Other frames insert idle cycles that carry stray line strobes, and scramble the coefficient and mode inputs in the middle of a frame. These show that capture happens only at a valid frame start and that pixel spacing does not move the coordinates.

// File: rtl/conic_pkg.sv
package conic_pkg;

   // accumulator width that holds a full-raster quadratic without overflow
   function automatic int acc_width(input int coef_w, input int xw, input int yw);
      int cw;
      cw = (xw > yw) ? xw : yw;
      return coef_w + 2 * cw + 3;
   endfunction

endpackage

// File: rtl/conic_coef_hold.sv
module conic_coef_hold #(
   parameter int COEF_W = 16,
   parameter int ACC_W  = 41
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture,
   input  logic                     narrow_in,
   input  logic signed [COEF_W-1:0] a_in,
   input  logic signed [COEF_W-1:0] b_in,
   input  logic signed [COEF_W-1:0] c_in,
   input  logic signed [COEF_W-1:0] d_in,
   input  logic signed [COEF_W-1:0] e_in,
   output logic                     eff_narrow,
   output logic signed [ACC_W-1:0]  eff_e,
   output logic signed [ACC_W-1:0]  dd_x,
   output logic signed [ACC_W-1:0]  dd_y,
   output logic signed [ACC_W-1:0]  row_d0,
   output logic signed [ACC_W-1:0]  px_d0,
   output logic signed [ACC_W-1:0]  px_d1,
   output logic [5*COEF_W:0]        held_state
);

   logic signed [COEF_W-1:0] h_a, h_b, h_c, h_d, h_e;
   logic                     h_n;
   logic signed [COEF_W-1:0] s_a, s_b, s_c, s_d, s_e;
   logic signed [ACC_W-1:0]  x_a, x_b, x_c, x_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_a <= '0;
         h_b <= '0;
         h_c <= '0;
         h_d <= '0;
         h_e <= '0;
         h_n <= 1'b0;
      end else if (capture) begin
         h_a <= a_in;
         h_b <= b_in;
         h_c <= c_in;
         h_d <= d_in;
         h_e <= e_in;
         h_n <= narrow_in;
      end
   end

   // the frame-start pixel itself must already see the new set
   always_comb begin
      s_a        = capture ? a_in : h_a;
      s_b        = capture ? b_in : h_b;
      s_c        = capture ? c_in : h_c;
      s_d        = capture ? d_in : h_d;
      s_e        = capture ? e_in : h_e;
      eff_narrow = capture ? narrow_in : h_n;
      x_a        = ACC_W'(s_a);
      x_b        = ACC_W'(s_b);
      x_c        = ACC_W'(s_c);
      x_d        = ACC_W'(s_d);
      eff_e      = ACC_W'(s_e);
      dd_x       = x_a <<< 1;
      dd_y       = x_b <<< 1;
      row_d0     = x_b + x_d;
      px_d0      = x_a + x_c;
      px_d1      = px_d0 + dd_x;
   end

   assign held_state = {h_a, h_b, h_c, h_d, h_e, h_n};

endmodule

// File: rtl/conic_fd_axis.sv
module conic_fd_axis #(
   parameter int W = 41
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                step,
   input  logic signed [W-1:0] load_val,
   input  logic signed [W-1:0] load_dlt,
   input  logic signed [W-1:0] dd,
   output logic signed [W-1:0] val,
   output logic signed [W-1:0] next_val
);

   logic signed [W-1:0] dlt;

   assign next_val = val + dlt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= '0;
         dlt <= '0;
      end else if (load) begin
         val <= load_val;
         dlt <= load_dlt;
      end else if (step) begin
         val <= next_val;
         dlt <= dlt + dd;
      end
   end

endmodule

// File: rtl/conic_out_stage.sv
module conic_out_stage #(
   parameter int ACC_W     = 41,
   parameter int NARROW_W  = 8,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_narrow,
   input  logic signed [ACC_W-1:0] in_f,
   output logic                    out_valid,
   output logic signed [ACC_W-1:0] out_value,
   output logic                    out_inside
);

   logic signed [ACC_W-1:0] sel_v;
   logic                    sel_s;

   generate
      if (NARROW_EN) begin : g_narrow
         logic signed [NARROW_W-1:0] low;
         assign low   = in_f[NARROW_W-1:0];
         assign sel_v = in_narrow ? ACC_W'(low) : in_f;
         assign sel_s = in_narrow ? in_f[NARROW_W-1] : in_f[ACC_W-1];
      end else begin : g_wide
         logic unused_n;
         assign unused_n = in_narrow;
         assign sel_v    = in_f;
         assign sel_s    = in_f[ACC_W-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_value  <= '0;
         out_inside <= 1'b0;
      end else begin
         out_valid  <= in_valid;
         out_value  <= in_valid ? sel_v : '0;
         out_inside <= in_valid & sel_s;
      end
   end

endmodule

// File: rtl/conic_raster.sv
module conic_raster #(
   parameter int COEF_W    = 16,
   parameter int X_W       = 11,
   parameter int Y_W       = 11,
   parameter int NARROW_W  = 8,
   parameter bit NARROW_EN = 1'b1,
   localparam int ACC_W    = conic_pkg::acc_width(COEF_W, X_W, Y_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pix_valid,
   input  logic                     frame_start,
   input  logic                     line_start,
   input  logic                     narrow,
   input  logic signed [COEF_W-1:0] coef_a,
   input  logic signed [COEF_W-1:0] coef_b,
   input  logic signed [COEF_W-1:0] coef_c,
   input  logic signed [COEF_W-1:0] coef_d,
   input  logic signed [COEF_W-1:0] coef_e,
   output logic                     out_valid,
   output logic signed [ACC_W-1:0]  out_value,
   output logic                     out_inside
);

   generate
      if (COEF_W < 2)              $error("COEF_W too small");
      if (X_W < 1 || Y_W < 1)      $error("coordinate widths must be positive");
      if (NARROW_W < 2 || NARROW_W > ACC_W) $error("NARROW_W out of range");
   endgenerate

   logic                    capture, at_line, row_step, px_step;
   logic                    eff_narrow;
   logic signed [ACC_W-1:0] eff_e, dd_x, dd_y, row_d0, px_d0, px_d1;
   logic signed [ACC_W-1:0] row_val, row_next, row_cur, px_val, px_next, f_now;
   logic [5*COEF_W:0]       held_state;
   logic signed [ACC_W-1:0] f_q;
   logic                    v_q, n_q;

   assign capture  = pix_valid & frame_start;
   assign at_line  = frame_start | line_start;
   assign row_step = pix_valid & line_start & ~frame_start;
   assign px_step  = pix_valid & ~at_line;

   conic_coef_hold #(.COEF_W(COEF_W), .ACC_W(ACC_W)) u_coef (
      .clk(clk), .rst_n(rst_n), .capture(capture), .narrow_in(narrow),
      .a_in(coef_a), .b_in(coef_b), .c_in(coef_c), .d_in(coef_d), .e_in(coef_e),
      .eff_narrow(eff_narrow), .eff_e(eff_e), .dd_x(dd_x), .dd_y(dd_y),
      .row_d0(row_d0), .px_d0(px_d0), .px_d1(px_d1), .held_state(held_state)
   );

   // row base f(0,y) and its y difference
   conic_fd_axis #(.W(ACC_W)) u_row (
      .clk(clk), .rst_n(rst_n), .load(capture), .step(row_step),
      .load_val(eff_e), .load_dlt(row_d0), .dd(dd_y),
      .val(row_val), .next_val(row_next)
   );

   assign row_cur = frame_start ? eff_e : row_next;

   // next pixel value along the line and its x difference
   conic_fd_axis #(.W(ACC_W)) u_px (
      .clk(clk), .rst_n(rst_n), .load(pix_valid & at_line), .step(px_step),
      .load_val(row_cur + px_d0), .load_dlt(px_d1), .dd(dd_x),
      .val(px_val), .next_val(px_next)
   );

   assign f_now = at_line ? row_cur : px_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q <= '0;
         v_q <= 1'b0;
         n_q <= 1'b0;
      end else begin
         f_q <= f_now;
         v_q <= pix_valid;
         n_q <= eff_narrow;
      end
   end

   conic_out_stage #(.ACC_W(ACC_W), .NARROW_W(NARROW_W), .NARROW_EN(NARROW_EN)) u_out (
      .clk(clk), .rst_n(rst_n), .in_valid(v_q), .in_narrow(n_q), .in_f(f_q),
      .out_valid(out_valid), .out_value(out_value), .out_inside(out_inside)
   );

   logic unused_ok;
   assign unused_ok = ^{row_val, px_next};

endmodule

// File: rtl/conic_raster_chk.sv
module conic_raster_chk #(
   parameter int ACC_W    = 41,
   parameter int NARROW_W = 8,
   parameter int HELD_W   = 81
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid,
   input logic              frame_start,
   input logic              eff_narrow,
   input logic [HELD_W-1:0] held_state,
   input logic              out_valid,
   input logic [ACC_W-1:0]  out_value,
   input logic              out_inside
);

   logic [1:0] cyc;
   logic       pv1, pv2, nm1, nm2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc <= '0;
         pv1 <= 1'b0;
         pv2 <= 1'b0;
         nm1 <= 1'b0;
         nm2 <= 1'b0;
      end else begin
         if (cyc != 2'd2) cyc <= cyc + 2'd1;
         pv1 <= pix_valid;
         pv2 <= pv1;
         nm1 <= eff_narrow;
         nm2 <= nm1;
      end
   end

   // R3
   valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2) |-> (out_valid == pv2));

   // R2
   inside_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_inside == out_value[ACC_W-1]));

   // R4
   narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2 && out_valid && nm2) |->
         ((&out_value[ACC_W-1:NARROW_W-1]) || !(|out_value[ACC_W-1:NARROW_W-1])));

   // R5
   coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pix_valid && frame_start) |=> $stable(held_state));

endmodule

bind conic_raster conic_raster_chk #(
   .ACC_W(ACC_W), .NARROW_W(NARROW_W), .HELD_W(5*COEF_W+1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
   .eff_narrow(eff_narrow), .held_state(held_state), .out_valid(out_valid),
   .out_value(out_value), .out_inside(out_inside)
);

// File: tb/conic_raster_bench.sv
module conic_raster_bench;

   localparam int COEF_W = 16;
   localparam int ACC_W  = conic_pkg::acc_width(16, 11, 11);

   typedef struct {
      logic signed [ACC_W-1:0] v;
      logic                    ins;
      string                   tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_valid = 1'b0, frame_start = 1'b0, line_start = 1'b0, narrow = 1'b0;
   logic signed [COEF_W-1:0] coef_a = '0, coef_b = '0, coef_c = '0, coef_d = '0, coef_e = '0;
   logic                    out_valid, out_inside;
   logic signed [ACC_W-1:0] out_value;

   int   checks = 0;
   int   failures = 0;
   exp_t q[$];
   logic h1 = 1'b0, h2 = 1'b0;

   always #2 clk = ~clk;

   conic_raster u_conic_raster (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .frame_start(frame_start),
      .line_start(line_start), .narrow(narrow), .coef_a(coef_a), .coef_b(coef_b),
      .coef_c(coef_c), .coef_d(coef_d), .coef_e(coef_e), .out_valid(out_valid),
      .out_value(out_value), .out_inside(out_inside)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: latency and scoreboard compare
   always @(negedge clk) begin
      if (rst_n) begin
         check(out_valid == h2, "R3 valid timing", longint'(out_valid), longint'(h2));
         if (out_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R3 unexpected output", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(out_value == e.v, e.tag, longint'(out_value), longint'(e.v));
               check(out_inside == e.ins, "R2 inside flag", longint'(out_inside), longint'(e.ins));
            end
         end
         h2 = h1;
         h1 = pix_valid;
      end
   end

   task automatic drive(input logic pv, input logic fs, input logic ls);
      @(posedge clk);
      #1;
      pix_valid   = pv;
      frame_start = fs;
      line_start  = ls;
   endtask

   // gap: insert idle cycles with stray strobes; scramble: disturb inputs mid-frame
   task automatic run_frame(input int w, input int h, input int a, input int b, input int c,
                            input int d, input int e, input bit nm, input bit gap,
                            input bit scramble, input string tag);
      @(posedge clk);
      #1;
      coef_a = COEF_W'(a); coef_b = COEF_W'(b); coef_c = COEF_W'(c);
      coef_d = COEF_W'(d); coef_e = COEF_W'(e); narrow = nm;
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            longint f;
            exp_t   it;
            logic [7:0] lo;
            f = longint'(a) * x * x + longint'(b) * y * y + longint'(c) * x
                + longint'(d) * y + longint'(e);
            if (nm) begin
               lo     = f[7:0];
               it.v   = ACC_W'($signed(lo));
               it.ins = lo[7];
            end else begin
               it.v   = ACC_W'(f);
               it.ins = (f < 0);
            end
            it.tag = tag;
            q.push_back(it);
            // R6: frame start pixel given with line_start low
            drive(1'b1, (x == 0 && y == 0), (x == 0 && y != 0));
            if (scramble && y == h / 2 && x == 1) begin
               coef_a = 16'sh1234; coef_b = -16'sd77; coef_c = 16'sd999;
               coef_d = -16'sd5; coef_e = 16'sd4321; narrow = ~nm;
            end
            if (gap && ((x + y) % 3 == 0)) begin
               drive(1'b0, (x == 2), 1'b1); // R7 stray strobes ignored
            end
         end
      end
      drive(1'b0, 1'b0, 1'b0);
   endtask

   task automatic settle();
      for (int i = 0; i < 6; i++) drive(1'b0, 1'b0, 1'b0);
      check(q.size() == 0, "R3 all results delivered", q.size(), 0);
   endtask

   initial begin
      #(4 * 190000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R9 during reset
      check(out_valid == 1'b0, "R9 valid in reset", longint'(out_valid), 0);
      check(out_value == '0, "R9 value in reset", longint'(out_value), 0);
      check(out_inside == 1'b0, "R9 inside in reset", longint'(out_inside), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 valid after reset", longint'(out_valid), 0);
      check(out_value == '0, "R9 value after reset", longint'(out_value), 0);

      // circle centred at (5,3) radius 3
      run_frame(12, 8, 1, 1, -10, -6, 25 + 9 - 9, 1'b0, 1'b0, 1'b0, "R1 R6 circle");
      settle();
      // hyperbola with idle gaps and stray strobes
      run_frame(9, 7, -3, 2, 40, -11, 17, 1'b0, 1'b1, 1'b0, "R1 R3 R7 hyperbola gaps");
      settle();
      // narrow wrapping mode
      run_frame(16, 10, 37, -91, 113, 55, -7, 1'b1, 1'b0, 1'b0, "R4 narrow wrap");
      settle();
      // mid-frame changes to coefficients and mode
      run_frame(10, 6, 2, -1, -20, 4, -30, 1'b0, 1'b0, 1'b1, "R5 held coefficients");
      settle();
      run_frame(10, 6, 5, 3, -70, -9, 100, 1'b1, 1'b1, 1'b1, "R5 R4 held mode");
      settle();
      // extremes for the accumulator width
      run_frame(2048, 2, -32768, -32768, -32768, -32768, -32768, 1'b0, 1'b0, 1'b0,
                "R8 wide line");
      settle();
      run_frame(2, 2048, -32768, -32768, -32768, -32768, -32768, 1'b0, 1'b0, 1'b0,
                "R8 tall column");
      settle();
      run_frame(2048, 1, 32767, 0, 32767, 0, 32767, 1'b0, 1'b0, 1'b0, "R8 positive line");
      settle();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule